// File: doc/BRIEF.md
# MDIO Management Master

This block is a clause 22 station-management master with a 32-bit register interface. Software uses two registers: a command word and a data word. For a write it first loads the 16-bit payload into the data word. It then writes the command word with the start bit set. The block serialises a full management frame onto the MDC/MDIO pins. For a read the data word receives the 16 bits sampled from the PHY when the frame ends.

MDC is derived from the system clock. A 3-bit range code in the command word selects the divide ratio, and the codes do not follow the order of the clock bands. Software polls the start bit: it reads 1 while a frame is on the wire, and the hardware clears it when the frame ends. The MDIO pin is exposed as a separate output, output-enable and input for an external pad.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset both registers read 0, MDC is low and the MDIO output enable is low.
- R2: The command word is at byte offset 0x10 and the data word at 0x14. Any other offset reads 0. Command fields are: start/busy bit 0, direction bit 1 (1 = write frame, 0 = read frame), range code bits 4:2, register number bits 10:6, PHY address bits 15:11. Bit 5 and bits 31:16 read 0. The data word occupies bits 15:0.
- R3: Writing the command word with bit 0 set starts a frame. Bit 0 reads 1 from the next cycle until the frame ends, and the hardware then clears it.
- R4: The MDC period in system clocks is 42, 62, 16, 26, 102 or 124 for range codes 0 to 5. Codes 6 and 7 use 124. MDC is low whenever no frame is running.
- R5: A write frame drives 64 bits MSB first, all with output enable high. The bits are 32 ones, 01, opcode 01, the PHY address, the register number, turnaround 10 and the 16 payload bits.
- R6: A read frame uses opcode 10. The output enable is high for the first 46 bits and low from the turnaround through the last data bit.
- R7: In a read frame, MDIO input is sampled on the MDC rising edges of bits 48 to 63, MSB first. The 16 bits appear in the data word once busy reads 0.
- R8: MDIO output never changes on a rising edge of MDC.
- R9: While busy is 1, bus writes to either register are ignored. The command fields, the data word and the running frame are unaffected.
- R10: After a write frame the data word still holds the payload that was sent.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 8 | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value driven to the pad |
| mdio_oe | output | 1 | MDIO pad output enable |
| mdio_i | input | 1 | MDIO value seen at the pad |

## Verification
The bench builds the block with its default parameters: an 8-bit bus address and a 7-bit half-period counter. The full divider table is therefore in use, and every range code, including the two fallback codes, is run through a complete frame. Even at the largest ratio a frame lasts under 8000 cycles, so the bench can cover every code, both directions and the writes issued during a running frame. A small PHY model in the bench captures each frame bit on MDC rising edges and drives read data on falling edges.

// File: rtl/mdm_pkg.sv
package mdm_pkg;
    localparam int PRE_BITS    = 32;
    localparam int FRAME_BITS  = 64;
    localparam int TA_START    = PRE_BITS + 14;
    localparam int DATA_START  = TA_START + 2;
    localparam int CNT_BITS    = $clog2(FRAME_BITS);

    typedef struct packed {
        logic [4:0] phy;
        logic [4:0] regn;
        logic [2:0] range;
        logic       is_write;
        logic       busy;
    } cmd_t;

    // half MDC period in system clocks for each range code
    function automatic logic [6:0] half_period(input logic [2:0] code);
        case (code)
            3'd0:    half_period = 7'd21;
            3'd1:    half_period = 7'd31;
            3'd2:    half_period = 7'd8;
            3'd3:    half_period = 7'd13;
            3'd4:    half_period = 7'd51;
            default: half_period = 7'd62;
        endcase
    endfunction

    function automatic logic [FRAME_BITS-1:0] build_frame(
        input logic is_write, input logic [4:0] phy,
        input logic [4:0] regn, input logic [15:0] payload);
        build_frame = {{PRE_BITS{1'b1}}, 2'b01,
                       (is_write ? 2'b01 : 2'b10), phy, regn, 2'b10, payload};
    endfunction
endpackage

// File: rtl/mdm_clkgen.sv
module mdm_clkgen #(
    parameter int HALF_W = 7
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic [2:0] code,
    output logic       mdc,
    output logic       rise,
    output logic       fall
);
    import mdm_pkg::*;

    logic [HALF_W-1:0] cnt;
    logic [HALF_W-1:0] half;
    logic              wrap;

    assign half = HALF_W'(half_period(code));
    assign wrap = en && (cnt == half - 1'b1);
    assign rise = wrap && !mdc;
    assign fall = wrap && mdc;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt <= '0;
            mdc <= 1'b0;
        end else if (wrap) begin
            cnt <= '0;
            mdc <= ~mdc;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_MDC_IDLE_LOW: assert property (@(posedge clk) disable iff (rst)
        !en |=> !mdc) else $error("mdc ran while idle"); // R4
endmodule

// File: rtl/mdm_frame.sv
module mdm_frame (
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic        is_write_i,
    input  logic [4:0]  phy_i,
    input  logic [4:0]  regn_i,
    input  logic [15:0] payload_i,
    input  logic        rise,
    input  logic        fall,
    input  logic        mdio_i,
    output logic        active,
    output logic        done,
    output logic        mdio_o,
    output logic        mdio_oe,
    output logic [15:0] rd_value
);
    import mdm_pkg::*;

    logic [FRAME_BITS-1:0] shreg;
    logic [CNT_BITS-1:0]   bitcnt;
    logic                  is_wr;
    logic                  last_bit;

    assign last_bit = (bitcnt == CNT_BITS'(FRAME_BITS - 1));
    assign done     = active && fall && last_bit;
    assign mdio_o   = active ? shreg[FRAME_BITS-1] : 1'b1;
    assign mdio_oe  = active && (is_wr || (bitcnt < CNT_BITS'(TA_START)));

    always_ff @(posedge clk) begin
        if (rst) begin
            active   <= 1'b0;
            bitcnt   <= '0;
            shreg    <= '0;
            is_wr    <= 1'b0;
            rd_value <= '0;
        end else if (start) begin
            active <= 1'b1;
            bitcnt <= '0;
            is_wr  <= is_write_i;
            shreg  <= build_frame(is_write_i, phy_i, regn_i, payload_i);
        end else if (active) begin
            if (rise && !is_wr && (bitcnt >= CNT_BITS'(DATA_START)))
                rd_value <= {rd_value[14:0], mdio_i};
            if (fall) begin
                shreg <= shreg << 1;
                if (last_bit) active <= 1'b0;
                else          bitcnt <= bitcnt + 1'b1;
            end
        end
    end

    AST_STABLE_ON_RISE: assert property (@(posedge clk) disable iff (rst)
        (active && rise) |=> $stable(mdio_o)) else $error("mdio moved on mdc rise"); // R8
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master #(
    parameter int ADDR_W = 8,
    parameter int HALF_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              mdc,
    output logic              mdio_o,
    output logic              mdio_oe,
    input  logic              mdio_i
);
    import mdm_pkg::*;

    localparam logic [ADDR_W-1:0] CMD_OFF  = ADDR_W'(8'h10);
    localparam logic [ADDR_W-1:0] DATA_OFF = ADDR_W'(8'h14);

    cmd_t        cmd_q;
    cmd_t        cmd_new;
    logic [15:0] data_q;
    logic        start;
    logic        active;
    logic        done;
    logic        rise;
    logic        fall;
    logic [15:0] rd_value;

    assign cmd_new = '{phy: bus_wdata[15:11], regn: bus_wdata[10:6],
                       range: bus_wdata[4:2], is_write: bus_wdata[1],
                       busy: bus_wdata[0]};
    assign start = bus_wr && !cmd_q.busy && (bus_addr == CMD_OFF) && bus_wdata[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q  <= '0;
            data_q <= '0;
        end else if (done) begin
            cmd_q.busy <= 1'b0;
            if (!cmd_q.is_write) data_q <= rd_value;
        end else if (bus_wr && !cmd_q.busy) begin
            if (bus_addr == CMD_OFF)  cmd_q  <= cmd_new;
            if (bus_addr == DATA_OFF) data_q <= bus_wdata[15:0];
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == CMD_OFF)
            bus_rdata = {16'd0, cmd_q.phy, cmd_q.regn, 1'b0, cmd_q.range,
                         cmd_q.is_write, cmd_q.busy};
        else if (bus_addr == DATA_OFF)
            bus_rdata = {16'd0, data_q};
    end

    mdm_clkgen #(.HALF_W(HALF_W)) u_clk (
        .clk(clk), .rst(rst), .en(active), .code(cmd_q.range),
        .mdc(mdc), .rise(rise), .fall(fall)
    );

    mdm_frame u_frame (
        .clk(clk), .rst(rst), .start(start),
        .is_write_i(bus_wdata[1]), .phy_i(bus_wdata[15:11]),
        .regn_i(bus_wdata[10:6]), .payload_i(data_q),
        .rise(rise), .fall(fall), .mdio_i(mdio_i),
        .active(active), .done(done), .mdio_o(mdio_o),
        .mdio_oe(mdio_oe), .rd_value(rd_value)
    );

    AST_DONE_CLEARS_BUSY: assert property (@(posedge clk) disable iff (rst)
        done |=> !cmd_q.busy) else $error("busy stuck after frame"); // R3
    AST_BUSY_TRACKS_FRAME: assert property (@(posedge clk) disable iff (rst)
        start |=> (cmd_q.busy && active)) else $error("start lost"); // R3
    AST_CMD_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (cmd_q.busy && !done) |=> $stable(cmd_q)) else $error("cmd changed while busy"); // R9
    AST_DATA_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (cmd_q.busy && !done) |=> $stable(data_q)) else $error("data changed while busy"); // R9
    AST_IDLE_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
        !cmd_q.busy |-> (!mdio_oe && !mdc)) else $error("pins active while idle"); // R4
endmodule

// File: tb/sim_mdio_mgmt_master.sv
`timescale 1ns/1ps
module sim_mdio_mgmt_master;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h00;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        mdc, mdio_o, mdio_oe;
    logic        mdio_i = 1'b1;

    int errors = 0;
    int checks = 0;

    logic [63:0] cap = '0;
    logic [63:0] oeh = '0;
    int          nrise = 0;
    realtime     t_prev = 0, t_last = 0;
    logic [15:0] phy_resp = 16'h0000;

    always #2 clk = ~clk;

    mdio_mgmt_master u0 (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mdc(mdc),
        .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
    );

    // PHY model: capture on rising MDC, drive response on falling MDC
    always @(posedge mdc) begin
        cap    <= {cap[62:0], mdio_o};
        oeh    <= {oeh[62:0], mdio_oe};
        nrise  <= nrise + 1;
        t_prev <= t_last;
        t_last <= $realtime;
    end
    always @(negedge mdc) begin
        automatic int idx = nrise % 64;
        mdio_i <= (idx >= 48) ? phy_resp[63 - idx] : 1'b1;
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 20000; i++) begin
            bus_read(8'h10, v);
            if (!v[0]) return;
        end
        check("R3 busy never cleared", 64'd1, 64'd0);
    endtask

    function automatic logic [31:0] cmd(input logic wr, input logic [2:0] code,
                                        input logic [4:0] phy, input logic [4:0] rg);
        return {16'd0, phy, rg, 1'b0, code, wr, 1'b1};
    endfunction

    task automatic t_reset();
        logic [31:0] v;
        bus_read(8'h10, v); check("R1 cmd after reset", 64'(v), 64'd0);
        bus_read(8'h14, v); check("R1 data after reset", 64'(v), 64'd0);
        check("R1 mdc/oe after reset", {62'd0, mdc, mdio_oe}, 64'd0);
    endtask

    task automatic t_write_code(input logic [2:0] code, input int ratio);
        logic [31:0] v;
        logic [15:0] pl = 16'hA5C3 ^ {13'd0, code};
        bus_write(8'h14, {16'hFFFF, pl});
        bus_write(8'h10, cmd(1'b1, code, 5'h13, 5'h0A));
        bus_read(8'h10, v);
        check("R3 busy reads 1 during frame", 64'(v[0]), 64'd1);
        wait_idle();
        check("R5 write frame bits", cap,
              {32'hFFFF_FFFF, 2'b01, 2'b01, 5'h13, 5'h0A, 2'b10, pl});
        check("R5 write frame enable", oeh, {64{1'b1}});
        check("R4 mdc period", 64'(int'((t_last - t_prev) / 4.0)), 64'(ratio));
        check("R4 mdc idle low", 64'(mdc), 64'd0);
        bus_read(8'h14, v);
        check("R10 data kept after write", 64'(v), 64'(pl));
        bus_read(8'h10, v);
        check("R2 cmd fields readback", 64'(v),
              64'({16'd0, 5'h13, 5'h0A, 1'b0, code, 1'b1, 1'b0}));
    endtask

    task automatic t_read(input logic [2:0] code, input logic [4:0] phy,
                          input logic [4:0] rg, input logic [15:0] resp);
        logic [31:0] v;
        phy_resp = resp;
        bus_write(8'h10, cmd(1'b0, code, phy, rg));
        wait_idle();
        check("R6 read frame header", 64'(cap[63:18]),
              64'({32'hFFFF_FFFF, 2'b01, 2'b10, phy, rg}));
        check("R6 read turnaround released", oeh, {{46{1'b1}}, 18'd0});
        bus_read(8'h14, v);
        check("R7 read data", 64'(v), 64'(resp));
    endtask

    task automatic t_ignore_busy();
        logic [31:0] v;
        bus_write(8'h14, 32'h0000_1234);
        bus_write(8'h10, cmd(1'b1, 3'd2, 5'h01, 5'h1F));
        bus_write(8'h14, 32'h0000_BEEF);
        bus_write(8'h10, cmd(1'b0, 3'd5, 5'h1E, 5'h02));
        wait_idle();
        check("R9 frame unaffected", cap,
              {32'hFFFF_FFFF, 2'b01, 2'b01, 5'h01, 5'h1F, 2'b10, 16'h1234});
        bus_read(8'h14, v);
        check("R9 data write ignored", 64'(v), 64'h1234);
        bus_read(8'h10, v);
        check("R9 cmd write ignored", 64'(v),
              64'({16'd0, 5'h01, 5'h1F, 1'b0, 3'd2, 1'b1, 1'b0}));
        repeat (40) @(negedge clk);
        check("R9 no second frame", {62'd0, mdc, mdio_oe}, 64'd0);
    endtask

    task automatic t_other_offset();
        logic [31:0] v;
        bus_read(8'h18, v); check("R2 unmapped offset reads 0", 64'(v), 64'd0);
        bus_read(8'h00, v); check("R2 offset 0 reads 0", 64'(v), 64'd0);
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_other_offset();
        t_write_code(3'd0, 42);
        t_write_code(3'd1, 62);
        t_write_code(3'd2, 16);
        t_write_code(3'd3, 26);
        t_write_code(3'd4, 102);
        t_write_code(3'd5, 124);
        t_write_code(3'd6, 124);
        t_write_code(3'd7, 124);
        t_read(3'd2, 5'h05, 5'h01, 16'h796D);
        t_read(3'd3, 5'h1F, 5'h1F, 16'h8001);
        t_ignore_busy();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule